// File: doc/BRIEF.md
# Burst-Read Banked Luma Shifter

This block sits on a cartridge port between a 6502-style host bus and a fast 32 KB SRAM. The SRAM is split into four 8 KB banks that all appear through one 8 KB host window, and a small write-only control register chooses which bank ordinary host accesses reach. With display mode off, the block behaves as a plain banked memory: reads return the selected bank and writes go to it.

With display mode on, every host read from the window starts a short burst on the fast clock. Within the read phase, the burst fetches the same 13-bit offset from bank 1, bank 2, bank 3 and finally bank 0. The first three bytes are captured for the pixel shifter. The bank 0 byte is left addressed and is then driven to the requester. The requester can be the CPU or the video DMA engine, so the display fetch addresses serve as video addresses and no separate address generator is needed.

The 24 captured bits are serialized on the fast clock, which also acts as the pixel clock. They come out as a 2-bit luma level, either one bit per pixel or bit pairs at half the horizontal resolution. Writes never start a burst.

Top module: `luma_burst_cart`

## Requirements
- R1: After reset the bank field is 0, display mode is off, `luma` is 0, `sram_we_n` is high and `host_rdata_oe` is low.
- R2: A host write with `ctrl_sel_n` low, `rw` low and `phi2` high loads the control register from `host_wdata[3:0]`. Bits [1:0] are the bank, bit 2 enables display mode and bit 3 selects the 2-bit pixel format. `host_rdata_oe` stays low during such an access.
- R3: With display mode off, a read with `cart_sel_n` low, `rw` high and `phi2` high sets `sram_addr = {bank, host_addr}` and drives `host_rdata_oe` high, with `host_rdata` equal to `sram_rdata`.
- R4: `sram_we_n` is low only while `cart_sel_n` is low, `rw` is low and `phi2` is high. During a write, `sram_addr = {bank, host_addr}` and `sram_wdata = host_wdata`, including in display mode.
- R5: In display mode, the first clock edge that samples `phi2` high after low, with `cart_sel_n` low and `rw` high, starts a burst. The burst addresses banks 1, 2, 3 and 0 in that order, each for STEP_TICKS clocks, and `host_rdata_oe` stays low throughout it.
- R6: After the burst, while the read continues, bank 0 at the read offset stays addressed and its byte is driven to the host with `host_rdata_oe` high.
- R7: In 1-bit format, from the first clock after the burst, the bank 1, bank 2 and bank 3 bytes are output MSB first, one bit per clock. A 1 bit gives level 3 and a 0 bit gives level 0.
- R8: In 2-bit format, the same 24 bits are output as 12 pairs, each held for two clocks. The first bit of each pair is the high bit of the level.
- R9: Once all 24 bits have been sent, `luma` is 0. With display mode off, reads start no burst and `luma` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, also the pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Host phase-2 clock, sampled on `clk` |
| rw | input | 1 | Host read (1) / write (0) |
| cart_sel_n | input | 1 | Active-low select of the 8 KB window |
| ctrl_sel_n | input | 1 | Active-low select of the control register |
| host_addr | input | 13 | Offset within the window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data toward the host |
| host_rdata_oe | output | 1 | Host data bus drive enable |
| sram_addr | output | 15 | SRAM address: bank in [14:13], offset below |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| luma | output | 2 | Serialized luma level |

## Verification
Plain reads are swept over all four bank settings and over offsets that include both ends of the window. A wrong bank field or a dropped address bit then returns a different byte. The SRAM model is an arithmetic function of address that differs per bank, so every byte identifies where it came from. Bursts are run in both pixel formats at several offsets, with the bank field set to a non-zero value, and each clock is compared against bank order, bus drive and bit position. This separates a swapped bank order, a wrong shift direction, a wrong pair hold and a missing zero tail. Writes are tried with display mode on and off and with the select missing, which shows whether the write strobe qualification and write bank selection hold.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    localparam int BANK_W = 2;
    localparam int NBANKS = 1 << BANK_W;

    typedef struct packed {
        logic            fmt2;
        logic            disp;
        logic [BANK_W-1:0] bank;
    } ctrl_t;
endpackage

// File: rtl/lbc_burst_seq.sv
module lbc_burst_seq #(
    parameter int DATA_W     = 8,
    parameter int STEP_TICKS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [DATA_W-1:0]       sram_rdata,
    output logic                    active,
    output logic [lbc_pkg::BANK_W-1:0] bank,
    output logic                    done,
    output logic [3*DATA_W-1:0]     cap_bits
);
    localparam int TICK_W = $clog2(STEP_TICKS + 1);
    localparam int BW     = lbc_pkg::BANK_W;

    typedef struct packed {
        logic                   active;
        logic [BW-1:0]          step;
        logic [TICK_W-1:0]      tick;
        logic [2:0][DATA_W-1:0] cap;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.step   = '0;
                st_d.tick   = '0;
            end
        end else if (st_q.tick == TICK_W'(STEP_TICKS - 1)) begin
            st_d.tick = '0;
            st_d.step = st_q.step + 1'b1;
            if (st_q.step == BW'(3)) begin
                st_d.active = 1'b0;
                done        = 1'b1;
            end else begin
                st_d.cap[st_q.step] = sram_rdata;
            end
        end else begin
            st_d.tick = st_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // step 0..3 visits bank 1,2,3,0
    assign active   = st_q.active;
    assign bank     = st_q.step + 1'b1;
    assign cap_bits = {st_q.cap[0], st_q.cap[1], st_q.cap[2]};
endmodule

// File: rtl/lbc_serializer.sv
module lbc_serializer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         fmt2_in,
    input  logic [W-1:0] data,
    output logic [1:0]   luma
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]     shift;
        logic [CNT_W-1:0] bits;
        logic             phase;
        logic             fmt2;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.shift = data;
            st_d.bits  = CNT_W'(W);
            st_d.phase = 1'b0;
            st_d.fmt2  = fmt2_in;
        end else if (st_q.bits != '0) begin
            if (st_q.fmt2) begin
                st_d.phase = ~st_q.phase;
                if (st_q.phase) begin
                    st_d.shift = st_q.shift << 2;
                    st_d.bits  = st_q.bits - CNT_W'(2);
                end
            end else begin
                st_d.shift = st_q.shift << 1;
                st_d.bits  = st_q.bits - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.bits == '0)  luma = 2'b00;
        else if (st_q.fmt2)   luma = st_q.shift[W-1 -: 2];
        else                  luma = {2{st_q.shift[W-1]}};
    end
endmodule

// File: rtl/luma_burst_cart.sv
module luma_burst_cart #(
    parameter int OFS_W      = 13,
    parameter int DATA_W     = 8,
    parameter int STEP_TICKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 phi2,
    input  logic                 rw,
    input  logic                 cart_sel_n,
    input  logic                 ctrl_sel_n,
    input  logic [OFS_W-1:0]     host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_rdata_oe,
    output logic [OFS_W+1:0]     sram_addr,
    output logic [DATA_W-1:0]    sram_wdata,
    input  logic [DATA_W-1:0]    sram_rdata,
    output logic                 sram_we_n,
    output logic                 sram_oe_n,
    output logic [1:0]           luma
);
    import lbc_pkg::*;

    localparam int CAP_W = 3 * DATA_W;

    typedef struct packed {
        ctrl_t ctrl;
        logic  phi2_prev;
    } top_t;

    top_t st_d, st_q;

    logic              cart_read;
    logic              start;
    logic              burst_active;
    logic              burst_done;
    logic [BANK_W-1:0] burst_bank;
    logic [BANK_W-1:0] bank_sel;
    logic [CAP_W-1:0]  cap_bits;
    logic              disp_on;

    always_comb begin
        st_d           = st_q;
        st_d.phi2_prev = phi2;
        if (phi2 && !ctrl_sel_n && !rw)
            st_d.ctrl = ctrl_t'(host_wdata[3:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp_on   = st_q.ctrl.disp;
    assign cart_read = !cart_sel_n && rw && phi2;
    assign start     = disp_on && cart_read && !st_q.phi2_prev;

    lbc_burst_seq #(
        .DATA_W     (DATA_W),
        .STEP_TICKS (STEP_TICKS)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .sram_rdata (sram_rdata),
        .active     (burst_active),
        .bank       (burst_bank),
        .done       (burst_done),
        .cap_bits   (cap_bits)
    );

    lbc_serializer #(
        .W (CAP_W)
    ) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (burst_done),
        .fmt2_in (st_q.ctrl.fmt2),
        .data    (cap_bits),
        .luma    (luma)
    );

    always_comb begin
        if (burst_active)      bank_sel = burst_bank;
        else if (disp_on && rw) bank_sel = '0;
        else                   bank_sel = st_q.ctrl.bank;
    end

    assign sram_addr     = {bank_sel, host_addr};
    assign sram_wdata    = host_wdata;
    assign sram_we_n     = !(!cart_sel_n && !rw && phi2);
    assign sram_oe_n     = !(cart_read || burst_active);
    assign host_rdata    = sram_rdata;
    assign host_rdata_oe = cart_read && !burst_active && !start;
endmodule

// File: rtl/luma_burst_cart_chk.sv
module luma_burst_cart_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phi2,
    input logic              rw,
    input logic              sram_we_n,
    input logic              host_rdata_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              burst_active,
    input logic              disp_on
);
    logic [1:0] bnk;
    assign bnk = sram_addr[ADDR_W-1 -: 2];

    AST_WE_NOT_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !host_rdata_oe); // R4

    AST_BURST_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |-> !host_rdata_oe); // R5

    AST_BURST_FIRST_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_active) |-> bnk == 2'd1); // R5

    AST_BURST_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && $past(burst_active) && bnk != $past(bnk))
            |-> bnk == 2'($past(bnk) + 2'd1)); // R5

    AST_BURST_ENDS_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(burst_active) && phi2 && rw) |-> bnk == 2'd0); // R6

    AST_NO_BURST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(disp_on) && !$past(burst_active)) |-> !burst_active); // R9
endmodule

bind luma_burst_cart luma_burst_cart_chk #(.ADDR_W(OFS_W + 2)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .phi2          (phi2),
    .rw            (rw),
    .sram_we_n     (sram_we_n),
    .host_rdata_oe (host_rdata_oe),
    .sram_addr     (sram_addr),
    .burst_active  (burst_active),
    .disp_on       (disp_on)
);

// File: tb/luma_burst_cart_tb_top.sv
module luma_burst_cart_tb_top;
    localparam int T = 2;
    localparam int BURST = 4 * T;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic        rw = 1'b1;
    logic        cart_sel_n = 1'b1;
    logic        ctrl_sel_n = 1'b1;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rdata_oe;
    logic [14:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata;
    logic        sram_we_n;
    logic        sram_oe_n;
    logic [1:0]  luma;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ {a[12:8], 3'b101} ^ 8'({6'b0, a[14:13]} * 8'h4B);
    endfunction

    assign sram_rdata = pat(sram_addr);

    luma_burst_cart #(.STEP_TICKS(T)) dut_i (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw),
        .cart_sel_n(cart_sel_n), .ctrl_sel_n(ctrl_sel_n),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .luma(luma)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [3:0] v);
        @(negedge clk);
        ctrl_sel_n = 1'b0; rw = 1'b0; host_wdata = {4'h0, v}; phi2 = 1'b1;
        @(negedge clk);
        chk(host_rdata_oe == 1'b0, "R2 oe", int'(host_rdata_oe), 0);
        phi2 = 1'b0; ctrl_sel_n = 1'b1; rw = 1'b1;
    endtask

    task automatic plain_read(input logic [12:0] ofs, input logic [1:0] b);
        @(negedge clk);
        host_addr = ofs; rw = 1'b1; cart_sel_n = 1'b0; phi2 = 1'b1;
        @(negedge clk);
        chk(host_rdata_oe == 1'b1, "R3 oe", int'(host_rdata_oe), 1);
        chk(sram_addr == {b, ofs}, "R3 addr", int'(sram_addr), int'({b, ofs}));
        chk(host_rdata == pat({b, ofs}), "R3 data", int'(host_rdata), int'(pat({b, ofs})));
        phi2 = 1'b0; cart_sel_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(luma == 2'b00, "R9 no burst when off", int'(luma), 0);
    endtask

    task automatic bus_write(input logic [12:0] ofs, input logic [7:0] d, input logic [1:0] b);
        @(negedge clk);
        host_addr = ofs; host_wdata = d; rw = 1'b0; cart_sel_n = 1'b0; phi2 = 1'b1;
        @(negedge clk);
        chk(sram_we_n == 1'b0, "R4 we low", int'(sram_we_n), 0);
        chk(sram_addr == {b, ofs}, "R4 addr", int'(sram_addr), int'({b, ofs}));
        chk(sram_wdata == d, "R4 wdata", int'(sram_wdata), int'(d));
        phi2 = 1'b0;
        #1;
        chk(sram_we_n == 1'b1, "R4 we phi2 low", int'(sram_we_n), 1);
        cart_sel_n = 1'b1;
        @(negedge clk);
        phi2 = 1'b1;
        #1;
        chk(sram_we_n == 1'b1, "R4 we unselected", int'(sram_we_n), 1);
        @(negedge clk);
        phi2 = 1'b0; rw = 1'b1;
        repeat (2) @(negedge clk);
        chk(luma == 2'b00, "R4 write no burst", int'(luma), 0);
    endtask

    task automatic disp_read(input logic [12:0] ofs, input bit fmt2);
        logic [23:0] d;
        d = {pat({2'd1, ofs}), pat({2'd2, ofs}), pat({2'd3, ofs})};
        @(negedge clk);
        host_addr = ofs; rw = 1'b1; cart_sel_n = 1'b0; phi2 = 1'b1;
        for (int i = 0; i < BURST + 32; i++) begin
            @(negedge clk);
            if (i < BURST) begin
                chk(host_rdata_oe == 1'b0, "R5 oe in burst", int'(host_rdata_oe), 0);
                chk(sram_addr[14:13] == 2'((i / T) + 1), "R5 bank order",
                    int'(sram_addr[14:13]), (i / T + 1) % 4);
            end
            if (i == BURST + 1) begin
                chk(host_rdata_oe == 1'b1, "R6 oe", int'(host_rdata_oe), 1);
                chk(host_rdata == pat({2'd0, ofs}), "R6 data",
                    int'(host_rdata), int'(pat({2'd0, ofs})));
            end
            if (i == BURST + 2) begin
                phi2 = 1'b0; cart_sel_n = 1'b1;
            end
            if (i >= BURST) begin
                int j;
                int e;
                j = i - BURST;
                if (j >= 24) begin
                    e = 0;
                    chk(luma == 2'(e), "R9 tail zero", int'(luma), e);
                end else if (fmt2) begin
                    e = int'(d[23 - 2 * (j / 2) -: 2]);
                    chk(luma == 2'(e), "R8 pair", int'(luma), e);
                end else begin
                    e = d[23 - j] ? 3 : 0;
                    chk(luma == 2'(e), "R7 bit", int'(luma), e);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(luma == 2'b00, "R1 luma", int'(luma), 0);
        chk(sram_we_n == 1'b1, "R1 we", int'(sram_we_n), 1);
        chk(host_rdata_oe == 1'b0, "R1 oe", int'(host_rdata_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(luma == 2'b00, "R1 luma after release", int'(luma), 0);
        plain_read(13'h0123, 2'd0);  // R1 bank 0 after reset

        for (int b = 0; b < 4; b++) begin
            ctrl_write(4'(b));  // R2 bank field
            plain_read(13'h0000, 2'(b));
            plain_read(13'h1FFF, 2'(b));
            plain_read(13'h0AA5, 2'(b));
            plain_read(13'h1234, 2'(b));
            bus_write(13'h0F0F, 8'(8'h3C ^ b), 2'(b));
        end

        for (int b = 0; b < 4; b++) begin
            ctrl_write(4'(4 | b));  // R2 display bit
            bus_write(13'h1555, 8'(8'hC3 + b), 2'(b));
        end

        ctrl_write(4'b0111);
        disp_read(13'h0000, 1'b0);
        disp_read(13'h1FFF, 1'b0);
        disp_read(13'h0B6D, 1'b0);

        ctrl_write(4'b1110);  // R2 format bit
        disp_read(13'h0000, 1'b1);
        disp_read(13'h1A2B, 1'b1);
        disp_read(13'h1FFF, 1'b1);

        ctrl_write(4'b1010);  // display off again
        plain_read(13'h0777, 2'd2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule